// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block writes one 16-bit value into a numbered configuration register of a display panel over a write-only serial link made of three lines: an active-low chip select, a serial clock and a data output. A host asserts a start strobe for one cycle, together with an 8-bit register index and a 16-bit value. The block then reports busy until the whole write is on the wire, and it ends with a one-cycle done pulse.

A write goes out as two separate chip-select frames of 24 bits each. The first frame selects the register. It carries a device header, a zero byte and the index. The second frame carries the same header with its register-select bit set, followed by the value, high byte first. The panel samples data on the rising clock edge. The data line changes only while the clock is low. Every step of the waveform lasts one delay unit. A delay unit is a parameterised count of system clocks, and its default gives about 1 µs at 100 MHz.

Top module: `panel_reg_writer`

## Requirements
- R1: Out of reset, and whenever not busy, chip select, serial clock and data out are all high, and busy and done are low.
- R2: A start strobe seen while idle makes busy high and chip select low on the next cycle. The first clock fall follows DELAY_CLKS cycles after the chip select fall.
- R3: Each bit is sent in three steps of DELAY_CLKS cycles each: clock low, then data updated, then clock high. Data out never changes while the clock is high and chip select is low.
- R4: Each frame has exactly 24 rising clock edges, and bits are sent most significant bit first.
- R5: The first frame carries 0x74, then 0x00, then the register index, in that order.
- R6: The second frame carries 0x76, then the value's bits 15..8, then bits 7..0.
- R7: In the first header byte (frame bits 23..16), bit 16 is the read flag and is always 0. Bit 17 is the register-select flag: it is 0 in the first frame and 1 in the second.
- R8: Chip select rises DELAY_CLKS cycles after the last rising clock edge of a frame. Between the two frames it stays high for DELAY_CLKS cycles before falling again.
- R9: A start strobe that arrives while busy is ignored. It adds no frame, does not change the values being sent, and produces no extra done pulse.
- R10: Done is a single-cycle pulse. It rises DELAY_CLKS cycles after the second frame's chip select rise, in the same cycle in which busy falls.
- R11: The serial clock is high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to write a register |
| reg_idx_i | input | 8 | Register index, captured on an accepted start |
| reg_val_i | input | 16 | Register value, captured on an accepted start |
| busy_o | output | 1 | High while a write is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a write |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock; the panel samples on its rising edge |
| sdo_o | output | 1 | Serial data out |

## Verification
The bound checker checks the following on every cycle:
- the idle line levels;
- data stability while the clock is high;
- that the clock is high whenever chip select is high;
- the count of rising edges in each frame;
- that a start taken while idle makes busy high and chip select low on the next cycle;
- the shape of the done pulse and its coincidence with busy falling.

Some behaviour can only be shown by the scoreboard scenarios:
- the byte content of each frame, for indexes and values at zero, all ones and mixed patterns;
- the exact widths of the lead, bit-step, trail and inter-frame gaps;
- that a strobe arriving in the middle of a write leaves no trace.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

    localparam int BYTE_W          = 8;
    localparam int IDX_W           = 8;
    localparam int VAL_W           = 16;
    localparam int BYTES_PER_FRAME = 3;
    localparam int FRAME_BITS      = BYTE_W * BYTES_PER_FRAME;
    localparam int BIT_CNT_W       = $clog2(FRAME_BITS);
    localparam int SEL_BIT         = 1;   // register-select flag position in header
    localparam int RW_BIT          = 0;   // read flag position in header, kept at 0

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_LEAD,
        ST_CLK_LO,
        ST_DATA,
        ST_CLK_HI,
        ST_CS_TRAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e             st;
        logic                   frame;
        logic [BIT_CNT_W-1:0]   bit_idx;
        logic                   cs_n;
        logic                   sclk;
        logic                   sdo;
        logic                   done;
        logic [IDX_W-1:0]       idx;
        logic [VAL_W-1:0]       val;
    } seq_regs_t;

endpackage

// File: rtl/pw_unit_timer.sv
module pw_unit_timer #(
    parameter int DELAY_CLKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic tick_o
);
    localparam int CNT_W = (DELAY_CLKS > 1) ? $clog2(DELAY_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CLKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (hold_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pw_frame_word.sv
module pw_frame_word
    import panel_wr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_HDR = 8'h74
) (
    input  logic                  second_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [VAL_W-1:0]      val_i,
    output logic [FRAME_BITS-1:0] word_o
);
    localparam logic [BYTE_W-1:0] RW_MASK  = BYTE_W'(1) << RW_BIT;
    localparam logic [BYTE_W-1:0] SEL_MASK = BYTE_W'(1) << SEL_BIT;
    localparam logic [BYTE_W-1:0] HDR_BASE = DEV_HDR & ~(RW_MASK | SEL_MASK);
    localparam logic [BYTE_W-1:0] HDR_DATA = HDR_BASE | SEL_MASK;

    always_comb begin
        if (second_i) begin
            word_o = {HDR_DATA, val_i};
        end else begin
            word_o = {HDR_BASE, {BYTE_W{1'b0}}, idx_i};
        end
    end
endmodule

// File: rtl/panel_reg_writer.sv
module panel_reg_writer
    import panel_wr_pkg::*;
#(
    parameter int                DELAY_CLKS = 100,
    parameter logic [BYTE_W-1:0] DEV_HDR    = 8'h74
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] reg_idx_i,
    input  logic [VAL_W-1:0] reg_val_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sdo_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

    seq_regs_t             r_d, r_q;
    logic                  tick;
    logic [FRAME_BITS-1:0] word;

    pw_unit_timer #(.DELAY_CLKS(DELAY_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (r_q.st == ST_IDLE),
        .tick_o (tick)
    );

    pw_frame_word #(.DEV_HDR(DEV_HDR)) u_word (
        .second_i (r_q.frame),
        .idx_i    (r_q.idx),
        .val_i    (r_q.val),
        .word_o   (word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_CS_LEAD;
                    r_d.cs_n    = 1'b0;
                    r_d.frame   = 1'b0;
                    r_d.bit_idx = '0;
                    r_d.idx     = reg_idx_i;
                    r_d.val     = reg_val_i;
                end
            end
            ST_CS_LEAD: begin
                if (tick) begin
                    r_d.st   = ST_CLK_LO;
                    r_d.sclk = 1'b0;
                end
            end
            ST_CLK_LO: begin
                if (tick) begin
                    r_d.st  = ST_DATA;
                    r_d.sdo = word[LAST_BIT - r_q.bit_idx];
                end
            end
            ST_DATA: begin
                if (tick) begin
                    r_d.st   = ST_CLK_HI;
                    r_d.sclk = 1'b1;
                end
            end
            ST_CLK_HI: begin
                if (tick) begin
                    if (r_q.bit_idx == LAST_BIT) begin
                        r_d.st   = ST_CS_TRAIL;
                        r_d.cs_n = 1'b1;
                        r_d.sdo  = 1'b1;
                    end else begin
                        r_d.st      = ST_CLK_LO;
                        r_d.sclk    = 1'b0;
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end
                end
            end
            ST_CS_TRAIL: begin
                if (tick) begin
                    if (!r_q.frame) begin
                        r_d.st      = ST_CS_LEAD;
                        r_d.frame   = 1'b1;
                        r_d.bit_idx = '0;
                        r_d.cs_n    = 1'b0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.cs_n    <= 1'b1;
            r_q.sclk    <= 1'b1;
            r_q.sdo     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign cs_n_o = r_q.cs_n;
    assign sclk_o = r_q.sclk;
    assign sdo_o  = r_q.sdo;
endmodule

// File: rtl/pw_checker.sv
module pw_checker
    import panel_wr_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sdo_o
);
    logic [BIT_CNT_W:0] rise_cnt_q;
    logic               sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q  <= '0;
            sclk_prev_q <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_o;
            if (cs_n_o) begin
                rise_cnt_q <= '0;
            end else if (sclk_o && !sclk_prev_q) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && sclk_o && sdo_o));

    a_r2_start_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !cs_n_o));

    a_r3_data_still_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !$stable(sdo_o)) |-> !sclk_o);

    a_r4_bits_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rise_cnt_q == (BIT_CNT_W+1)'(FRAME_BITS)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r11_clk_high_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
endmodule

bind panel_reg_writer pw_checker u_pw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o)
);

// File: tb/panel_reg_writer_test.sv
module panel_reg_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  idx = '0;
    logic [15:0] val = '0;
    logic        busy, done, cs_n, sclk, sdo;

    panel_reg_writer #(.DELAY_CLKS(DLY)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .reg_idx_i (idx),
        .reg_val_i (val),
        .busy_o    (busy),
        .done_o    (done),
        .cs_n_o    (cs_n),
        .sclk_o    (sclk),
        .sdo_o     (sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor state
    int          ncyc = 0, t_csfall = 0, t_fall = 0, t_rise = 0, t_csrise = 0;
    int          nbits = 0, frames = 0, ndone = 0;
    bit          first = 0, fidx = 0;
    logic        p_cs = 1, p_sclk = 1, p_done = 0;
    logic [23:0] word = '0, e;

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                t_csfall = ncyc; nbits = 0; word = '0; first = 1;
                if (fidx) chk(ncyc - t_csrise == DLY, "R8", "inter-frame gap", ncyc - t_csrise, DLY);
            end
            if (!cs_n && p_sclk && !sclk) begin
                if (first) chk(ncyc - t_csfall == DLY, "R2", "lead before first fall", ncyc - t_csfall, DLY);
                first = 0; t_fall = ncyc;
            end
            if (!cs_n && !p_sclk && sclk) begin
                chk(ncyc - t_fall == 2*DLY, "R3", "clock low span", ncyc - t_fall, 2*DLY);
                word = {word[22:0], sdo}; nbits++; t_rise = ncyc;
            end
            if (!p_cs && cs_n) begin
                chk(nbits == 24, "R4", "bits in frame", nbits, 24);
                chk(ncyc - t_rise == DLY, "R8", "trail after last rise", ncyc - t_rise, DLY);
                chk(sclk == 1'b1, "R11", "clock at deselect", sclk, 1);
                chk(word[16] == 1'b0, "R7", "read flag", word[16], 0);
                chk(word[17] == fidx, "R7", "select flag", word[17], fidx);
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected frame", word, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(word == e, fidx ? "R6" : "R5", "frame content", word, e);
                end
                t_csrise = ncyc; fidx = ~fidx; frames++;
            end
            if (done) begin
                chk(!p_done, "R10", "done width", p_done, 0);
                chk(ncyc - t_csrise == DLY && !fidx, "R10", "done timing", ncyc - t_csrise, DLY);
                chk(!busy, "R10", "busy falls with done", busy, 0);
                ndone++;
            end
        end
        p_cs = cs_n; p_sclk = sclk; p_done = done;
    end

    task automatic do_write(input logic [7:0] i, input logic [15:0] v, input bit push);
        if (push) begin
            exp_q.push_back({8'h74, 8'h00, i});
            exp_q.push_back({8'h76, v});
        end
        @(negedge clk);
        idx = i; val = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cs_n, "R2", "busy and select after start", {busy, cs_n}, 2'b10);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(cs_n && sclk && sdo && !busy && !done, "R1", "idle lines after write",
            {cs_n, sclk, sdo, busy, done}, 5'b11100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && sdo && !busy && !done, "R1", "lines in reset",
            {cs_n, sclk, sdo, busy, done}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && sdo && !busy && !done, "R1", "lines after reset",
            {cs_n, sclk, sdo, busy, done}, 5'b11100);

        do_write(8'h07, 16'h0000, 1); wait_done();
        do_write(8'h12, 16'h1618, 1); wait_done();
        do_write(8'hFF, 16'hFFFF, 1); wait_done();
        do_write(8'h00, 16'hA5C3, 1); wait_done();

        // R9: strobe in the middle of a write must leave no trace
        begin
            int f0, d0;
            f0 = frames; d0 = ndone;
            do_write(8'h3C, 16'h6650, 1);
            repeat (50) @(negedge clk);
            idx = 8'hEE; val = 16'h1234; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            repeat (20 * DLY) @(negedge clk);
            chk(frames - f0 == 2, "R9", "frames for one write", frames - f0, 2);
            chk(ndone - d0 == 1, "R9", "done pulses", ndone - d0, 1);
            chk(exp_q.size() == 0, "R9", "pending expected frames", exp_q.size(), 0);
            chk(cs_n && !busy, "R9", "stays idle", {cs_n, busy}, 2'b10);
        end

        chk(ndone == 5, "R10", "total done pulses", ndone, 5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule